// File: doc/BRIEF.md
# Baud Divisor Computation Engine

This engine turns a reference clock frequency and a requested baud rate into the settings a UART baud generator needs. It chooses one of three oversampling modes and computes a 16-bit divisor. It also computes the sample-count and sample-point register values and, in one case, a flag that marks the achieved rate as off-target. A configuration bit forces the finest oversampling mode for every rate.

Software or a boot sequencer places the frequency, the rate and the force bit on the inputs and pulses `start`. The engine then runs a serial restoring divider one to three times, one quotient bit per cycle. It raises `done` for one cycle with the results, which stay on the outputs until the next request. No combinational divide is used.

Mode codes are fixed because the baud generator decodes them. Code 0 is 16x oversampling, code 2 is 4x oversampling and code 3 is programmable oversampling with a sample count. Code 1 is never produced.

Top module: `baud_div_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `tol_fail`, `mode`, `divisor`, `samp_cnt` and `samp_pt` are all zero.
- R2: When `ref_hz` equals 12,000,000 and `baud` is at most 115200, the mode is 3. The divisor is (C + 128·B)/(256·B), replaced by 1 when that gives 0. The sample count is (C + ⌊q·B/2⌋)/(q·B). This case takes precedence over `force_fine`.
- R3: In the case of R2, the achieved rate is ⌊C/(sc·q)⌋. `tol_fail` is 1 when the achieved rate ×100 exceeds B·(100+TOL_PCT) or is below B·(100−TOL_PCT). With TOL_PCT = 0, any inexact rate sets the flag. In every other case `tol_fail` is 0.
- R4: With `force_fine` = 1, outside the R2 case, the mode is 3 and the rules of R7 apply whatever the rate.
- R5: With `force_fine` = 0 and 0 < B ≤ 115200, outside the R2 case, the mode is 0 and the divisor is (C + 8·B)/(16·B).
- R6: With `force_fine` = 0 and 115200 < B ≤ 576000, the mode is 2. Requests of exactly 500000 or 576000 are first replaced by 460800. The divisor is ⌈C/(4·B)⌉.
- R7: With B > 576000, the mode is 3, the divisor is ⌈C/(256·B)⌉ and the sample count is (C + ⌊q·B/2⌋)/(q·B).
- R8: Register encoding:
  - `samp_cnt` = sc−1 and `samp_pt` = ⌊(sc−2)/2⌋, both taken from the low CNT_W bits of a 32-bit unsigned result.
  - In modes 0 and 2, sc is 1, which gives `samp_cnt` = 0 and `samp_pt` all ones.
- R9: `err` is set together with `done` in any of these cases, and mode, divisor, `samp_cnt`, `samp_pt` and `tol_fail` are then zero:
  - the baud is zero;
  - the divisor is 0 or above 65535;
  - in mode 3, the sample count is 0 or above 2^CNT_W.
- R10: `start` is accepted only while `busy` is 0. `busy` is 1 from the cycle after acceptance until `done`. `done` is a one-cycle pulse. A `start` pulse while busy has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted while idle |
| ref_hz | input | REF_W (32) | Reference clock frequency in Hz |
| baud | input | BAUD_W (32) | Requested baud rate |
| force_fine | input | 1 | Force mode 3 for every rate |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Request could not be encoded |
| mode | output | 2 | Oversampling mode code (0, 2 or 3) |
| divisor | output | DIV_OUT_W (16) | Baud divisor |
| samp_cnt | output | CNT_W (16) | Sample-count register value |
| samp_pt | output | CNT_W (16) | Sample-point register value |
| tol_fail | output | 1 | Achieved rate outside the tolerance band |

## Verification
Requests are chosen on both sides of each threshold: 115200 against 120000, 460800 against 500000 and 576000, and 576000 against 921600. This separates mode selection from the rounding rule each mode uses. Divisors whose exact quotient lies just above an integer (26.04 and 52.08) tell round-to-nearest apart from ceiling. The 12 MHz reference is tried with and without the force bit, and against a 48 MHz reference with the force bit, to show which rule takes precedence. A strict-tolerance second instance shows that the achieved-rate check sees an inexact rate (115384 against 115200) and accepts an exact one (9600). A zero baud, an oversized divisor, a zero sample count and a stray start pulse during a run cover the error and handshake paths.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
   typedef enum logic [1:0] {
      MODE_X16  = 2'd0,
      MODE_X4   = 2'd2,
      MODE_FINE = 2'd3
   } os_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_QUOT = 2'd1,
      ST_SCNT = 2'd2,
      ST_RATE = 2'd3
   } eng_state_e;

   localparam longint unsigned LOW_REF_HZ  = 64'd12_000_000;
   localparam longint unsigned X16_MAX     = 64'd115_200;
   localparam longint unsigned X4_MAX      = 64'd576_000;
   localparam longint unsigned X4_FALLBACK = 64'd460_800;
   localparam longint unsigned X4_ODD_A    = 64'd500_000;
   localparam longint unsigned X4_ODD_B    = 64'd576_000;
endpackage

// File: rtl/baud_div_serial.sv
module baud_div_serial #(
   parameter int W = 50
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         valid,
   output logic [W-1:0] quo
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  acc, qr, dv;
   logic [CW-1:0] cnt;
   logic          run;
   logic [W:0]    shl, trial;

   generate
      if (W < 8) begin : g_bad_w
         $error("baud_div_serial: W too small");
      end
   endgenerate

   assign shl   = {acc, qr[W-1]};
   assign trial = shl - {1'b0, dv};
   assign quo   = qr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc   <= '0;
         qr    <= '0;
         dv    <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (go) begin
            acc <= '0;
            qr  <= num;
            dv  <= den;
            cnt <= CW'(W);
            run <= 1'b1;
         end else if (run) begin
            if (!trial[W]) begin
               acc <= trial[W-1:0];
               qr  <= {qr[W-2:0], 1'b1};
            end else begin
               acc <= shl[W-1:0];
               qr  <= {qr[W-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               run   <= 1'b0;
               valid <= 1'b1;
            end
         end
      end
   end

   // R10: the controller never relaunches a division in flight
   p_no_relaunch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !run);
   // R7: each division reports exactly once
   p_valid_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
endmodule

// File: rtl/baud_tol_chk.sv
module baud_tol_chk #(
   parameter int W       = 50,
   parameter int TOL_PCT = 3
) (
   input  logic [W-1:0] rate,
   input  logic [W-1:0] req,
   output logic         bad
);
   localparam int EW = W + 8;

   generate
      if (TOL_PCT < 0 || TOL_PCT > 99) begin : g_bad_tol
         $error("baud_tol_chk: TOL_PCT out of range");
      end
      if (TOL_PCT == 0) begin : g_exact
         assign bad = (rate != req);
      end else begin : g_band
         logic [EW-1:0] got, hi, lo;
         assign got = EW'(rate) * EW'(100);
         assign hi  = EW'(req) * EW'(100 + TOL_PCT);
         assign lo  = EW'(req) * EW'(100 - TOL_PCT);
         assign bad = (got > hi) || (got < lo);
      end
   endgenerate
endmodule

// File: rtl/baud_div_engine.sv
module baud_div_engine
   import baud_div_pkg::*;
#(
   parameter int REF_W     = 32,
   parameter int BAUD_W    = 32,
   parameter int DIV_OUT_W = 16,
   parameter int CNT_W     = 16,
   parameter int TOL_PCT   = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [REF_W-1:0]     ref_hz,
   input  logic [BAUD_W-1:0]    baud,
   input  logic                 force_fine,
   output logic                 busy,
   output logic                 done,
   output logic                 err,
   output logic [1:0]           mode,
   output logic [DIV_OUT_W-1:0] divisor,
   output logic [CNT_W-1:0]     samp_cnt,
   output logic [CNT_W-1:0]     samp_pt,
   output logic                 tol_fail
);
   localparam int DW = BAUD_W + DIV_OUT_W + 2;
   localparam logic [DW-1:0] Q_MAX  = DW'((64'd1 << DIV_OUT_W) - 1);
   localparam logic [DW-1:0] SC_MAX = DW'(64'd1 << CNT_W);

   generate
      if (REF_W < 24 || REF_W > 32) begin : g_bad_ref
         $error("baud_div_engine: REF_W must be 24..32");
      end
      if (BAUD_W < 20 || BAUD_W > 32) begin : g_bad_baud
         $error("baud_div_engine: BAUD_W must be 20..32");
      end
      if (DIV_OUT_W < 8 || DIV_OUT_W > 24) begin : g_bad_div
         $error("baud_div_engine: DIV_OUT_W must be 8..24");
      end
      if (CNT_W < 8 || CNT_W > 32) begin : g_bad_cnt
         $error("baud_div_engine: CNT_W must be 8..32");
      end
   endgenerate

   eng_state_e    st;
   os_mode_e      m_q, m_sel;
   logic          low_q, fix_q, low_sel;
   logic [DW-1:0] c_q, b_q, c_in, b_in, b_x4, den_sel, bias_sel;
   logic [DW-1:0] dnum, dden, dquo, qx, prod;
   logic [DIV_OUT_W-1:0] q_q;
   logic          dgo, dvalid, rate_bad;

   assign c_in = DW'(ref_hz);
   assign b_in = DW'(baud);
   assign busy = (st != ST_IDLE);

   // request classification and first-division operands
   always_comb begin
      low_sel = (64'(ref_hz) == LOW_REF_HZ) && (64'(baud) <= X16_MAX);
      b_x4    = ((64'(baud) == X4_ODD_A) || (64'(baud) == X4_ODD_B)) ? DW'(X4_FALLBACK) : b_in;
      if (low_sel) begin
         m_sel    = MODE_FINE;
         den_sel  = b_in << 8;
         bias_sel = den_sel >> 1;
      end else if (force_fine || (64'(baud) > X4_MAX)) begin
         m_sel    = MODE_FINE;
         den_sel  = b_in << 8;
         bias_sel = den_sel - 1'b1;
      end else if (64'(baud) <= X16_MAX) begin
         m_sel    = MODE_X16;
         den_sel  = b_in << 4;
         bias_sel = den_sel >> 1;
      end else begin
         m_sel    = MODE_X4;
         den_sel  = b_x4 << 2;
         bias_sel = den_sel - 1'b1;
      end
   end

   always_comb begin
      qx = dquo;
      if (low_q && (dquo == '0)) qx = DW'(1);
      prod = DW'(qx[DIV_OUT_W-1:0]) * b_q;
   end

   baud_div_serial #(.W(DW)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (dgo),
      .num   (dnum),
      .den   (dden),
      .valid (dvalid),
      .quo   (dquo)
   );

   baud_tol_chk #(.W(DW), .TOL_PCT(TOL_PCT)) u_tol (
      .rate (dquo),
      .req  (b_q),
      .bad  (rate_bad)
   );

   function automatic logic [CNT_W-1:0] enc_cnt(input logic [DW-1:0] sc);
      logic [DW-1:0] t;
      t = sc - 1'b1;
      return t[CNT_W-1:0];
   endfunction

   function automatic logic [CNT_W-1:0] enc_pt(input logic [DW-1:0] sc);
      logic [DW-1:0] t;
      t = (sc - DW'(2)) >> 1;
      return t[CNT_W-1:0];
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         m_q      <= MODE_X16;
         low_q    <= 1'b0;
         fix_q    <= 1'b0;
         c_q      <= '0;
         b_q      <= '0;
         q_q      <= '0;
         dnum     <= '0;
         dden     <= '0;
         dgo      <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
         mode     <= 2'd0;
         divisor  <= '0;
         samp_cnt <= '0;
         samp_pt  <= '0;
         tol_fail <= 1'b0;
      end else begin
         dgo  <= 1'b0;
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               c_q   <= c_in;
               b_q   <= b_in;
               low_q <= low_sel;
               fix_q <= force_fine;
               m_q   <= m_sel;
               if (baud == '0) begin
                  done <= 1'b1; err <= 1'b1; mode <= 2'd0; divisor <= '0;
                  samp_cnt <= '0; samp_pt <= '0; tol_fail <= 1'b0;
               end else begin
                  dnum <= c_in + bias_sel;
                  dden <= den_sel;
                  dgo  <= 1'b1;
                  st   <= ST_QUOT;
               end
            end
            ST_QUOT: if (dvalid) begin
               if ((qx == '0) || (qx > Q_MAX)) begin
                  st <= ST_IDLE; done <= 1'b1; err <= 1'b1; mode <= 2'd0;
                  divisor <= '0; samp_cnt <= '0; samp_pt <= '0; tol_fail <= 1'b0;
               end else if (m_q == MODE_FINE) begin
                  q_q  <= qx[DIV_OUT_W-1:0];
                  dnum <= c_q + (prod >> 1);
                  dden <= prod;
                  dgo  <= 1'b1;
                  st   <= ST_SCNT;
               end else begin
                  st <= ST_IDLE; done <= 1'b1; err <= 1'b0; mode <= m_q;
                  divisor  <= qx[DIV_OUT_W-1:0];
                  samp_cnt <= enc_cnt(DW'(1));
                  samp_pt  <= enc_pt(DW'(1));
                  tol_fail <= 1'b0;
               end
            end
            ST_SCNT: if (dvalid) begin
               samp_cnt <= enc_cnt(dquo);
               samp_pt  <= enc_pt(dquo);
               divisor  <= q_q;
               mode     <= m_q;
               tol_fail <= 1'b0;
               if ((dquo == '0) || (dquo > SC_MAX)) begin
                  st <= ST_IDLE; done <= 1'b1; err <= 1'b1; mode <= 2'd0;
                  divisor <= '0; samp_cnt <= '0; samp_pt <= '0;
               end else if (low_q) begin
                  dnum <= c_q;
                  dden <= dquo * DW'(q_q);
                  dgo  <= 1'b1;
                  st   <= ST_RATE;
               end else begin
                  st <= ST_IDLE; done <= 1'b1; err <= 1'b0;
               end
            end
            ST_RATE: if (dvalid) begin
               tol_fail <= rate_bad;
               err      <= 1'b0;
               done     <= 1'b1;
               st       <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R10: done is a single-cycle strobe and coincides with the return to idle
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R5: mode code 1 never leaves the engine
   p_no_mode1_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (mode != 2'd1));
   // R8: coarse modes carry the unit sample-count encoding
   p_coarse_enc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err && (mode != 2'd3)) |-> ((samp_cnt == '0) && (samp_pt == '1)));
   // R9: an error leaves the settings cleared
   p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> ((divisor == '0) && (mode == 2'd0) && !tol_fail));
   // R4: the force bit always lands in mode 3
   p_force_fine_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err && fix_q) |-> (mode == 2'd3));
   // R3: the tolerance flag only appears with mode 3
   p_tol_fine_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tol_fail |-> (mode == 2'd3));
   // R2: a successful result never carries a zero divisor
   p_div_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (divisor != '0));
endmodule

// File: tb/baud_div_engine_bench.sv
module baud_div_engine_bench;
   typedef struct {
      bit          err;
      bit [1:0]    mode;
      bit [15:0]   dv;
      bit [15:0]   cnt;
      bit [15:0]   pt;
      bit          tol;
      bit          tight;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] ref_hz = '0;
   logic [31:0] baud = '0;
   logic        force_fine = 1'b0;
   logic        busy, done, err, tol_fail;
   logic [1:0]  mode;
   logic [15:0] divisor, samp_cnt, samp_pt;
   logic        t_busy, t_done, t_err, t_tol;
   logic [1:0]  t_mode;
   logic [15:0] t_div, t_cnt, t_pt;

   int   n_run = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   baud_div_engine u_baud_div_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz), .baud(baud),
      .force_fine(force_fine), .busy(busy), .done(done), .err(err), .mode(mode),
      .divisor(divisor), .samp_cnt(samp_cnt), .samp_pt(samp_pt), .tol_fail(tol_fail));

   baud_div_engine #(.TOL_PCT(0)) u_baud_div_engine_tight (
      .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz), .baud(baud),
      .force_fine(force_fine), .busy(t_busy), .done(t_done), .err(t_err), .mode(t_mode),
      .divisor(t_div), .samp_cnt(t_cnt), .samp_pt(t_pt), .tol_fail(t_tol));

   task automatic check(input string tag, input string what, input longint unsigned got,
                        input longint unsigned want);
      n_run++;
      if (got != want) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, want);
      end
   endtask

   function automatic exp_t model(input longint unsigned c, input longint unsigned b,
                                  input bit f, input string tag);
      exp_t e;
      longint unsigned q, sc, rate, d;
      bit low;
      e.err = 0; e.mode = 0; e.dv = 0; e.cnt = 0; e.pt = 0; e.tol = 0; e.tight = 0;
      e.tag = tag;
      if (b == 0) begin e.err = 1; return e; end
      low = (c == 64'd12000000) && (b <= 64'd115200);
      sc = 1;
      if (low) begin
         e.mode = 3; d = 256 * b; q = (c + d / 2) / d; if (q == 0) q = 1;
      end else if (f || b > 64'd576000) begin
         e.mode = 3; d = 256 * b; q = (c + d - 1) / d;
      end else if (b <= 64'd115200) begin
         e.mode = 0; d = 16 * b; q = (c + d / 2) / d;
      end else begin
         e.mode = 2;
         d = 4 * ((b == 64'd500000 || b == 64'd576000) ? 64'd460800 : b);
         q = (c + d - 1) / d;
      end
      if (q == 0 || q > 65535) begin e.err = 1; e.mode = 0; return e; end
      if (e.mode == 3) begin
         sc = (c + (q * b) / 2) / (q * b);
         if (sc == 0 || sc > 65536) begin e.err = 1; e.mode = 0; return e; end
      end
      e.dv  = 16'(q);
      e.cnt = 16'((sc - 1) & 64'hFFFF_FFFF);
      e.pt  = 16'(((sc - 2) & 64'hFFFF_FFFF) >> 1);
      if (low) begin
         rate = c / (sc * q);
         e.tol   = (rate * 100 > b * 103) || (rate * 100 < b * 97);
         e.tight = (rate != b);
      end
      return e;
   endfunction

   task automatic run_case(input longint unsigned c, input longint unsigned b,
                           input bit f, input string tag);
      sb.push_back(model(c, b, f, tag));
      @(negedge clk);
      ref_hz = 32'(c); baud = 32'(b); force_fine = f; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (sb.size() != 0) @(negedge clk);
   endtask

   // monitor: pops the scoreboard on every result strobe
   initial begin
      forever begin
         @(posedge clk); #1;
         if (done) begin
            if (sb.size() == 0) begin
               check("R10", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(e.tag, "err", err, e.err);
               check(e.tag, "mode", mode, e.mode);
               check(e.tag, "divisor", divisor, e.dv);
               check(e.tag, "samp_cnt", samp_cnt, e.cnt);
               check(e.tag, "samp_pt", samp_pt, e.pt);
               check("R3", "tol_fail", tol_fail, e.tol);
               check("R3", "tight tol_fail", t_done ? t_tol : 1'bx, e.tight);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "busy", busy, 0);
      check("R1", "done", done, 0);
      check("R1", "outputs", {err, tol_fail, mode, divisor, samp_cnt, samp_pt}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_case(64'd12000000, 64'd115200, 0, "R2");
      run_case(64'd12000000, 64'd9600,   0, "R2");
      run_case(64'd12000000, 64'd9600,   1, "R4");
      run_case(64'd48000000, 64'd115200, 0, "R5");
      run_case(64'd26000000, 64'd9600,   0, "R5");
      run_case(64'd12000000, 64'd120000, 0, "R6");
      run_case(64'd48000000, 64'd460800, 0, "R6");
      run_case(64'd48000000, 64'd500000, 0, "R6");
      run_case(64'd48000000, 64'd576000, 0, "R6");
      run_case(64'd48000000, 64'd230400, 0, "R6");
      run_case(64'd48000000, 64'd921600, 0, "R7");
      run_case(64'd48000000, 64'd3000000, 0, "R7");
      run_case(64'd48000000, 64'd115200, 1, "R4");
      run_case(64'd48000000, 64'd460800, 1, "R4");
      run_case(64'd48000000, 64'd0,      0, "R9");
      run_case(64'd4000000000, 64'd1,    0, "R9");
      run_case(64'd1000000,  64'd3000000, 0, "R9");

      // R10: busy after acceptance, stray start ignored mid-run
      sb.push_back(model(64'd48000000, 64'd921600, 0, "R10"));
      @(negedge clk);
      ref_hz = 32'd48000000; baud = 32'd921600; force_fine = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R10", "busy after start", busy, 1);
      repeat (10) @(negedge clk);
      ref_hz = 32'd26000000; baud = 32'd9600; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
      check("R10", "busy after done", busy, 0);
      check("R10", "done width", done, 0);

      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule